// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load-Use Interlock

This control block sits beside the datapath of a five-stage in-order pipeline. It works out where the two ALU operands of the instruction in execute should come from. Each operand can come from the register file, from the result held in the execute/memory register, or from the value held in the memory/writeback register. When both later registers would write the needed register, the newer execute/memory value wins.

It also detects a load whose result is needed by the very next instruction. That value only exists after the memory stage, so bypassing cannot supply it in time. In that case the block raises `stall` and `bubble` together for one cycle. `stall` freezes the PC and the fetch/decode register. `bubble` turns the decode/execute register into a no-op. Older instructions keep moving. After the stall, the loaded value reaches the consumer through the memory/writeback bypass.

All inputs are plain register numbers and flags taken from the pipeline registers. No data flows through the block, so it has no valid/ready interface and no back-pressure. The only state is a one-bit register that limits each interlock to a single cycle.

Top module: `hazard_unit`

## Requirements
- R1: The operand selects use the codes 2'b00 = register file, 2'b01 = memory/writeback value and 2'b10 = execute/memory value. An execute source matching `mem_rd` while `mem_wen` is high selects 2'b10.
- R2: An execute source that matches `wb_rd` while `wb_wen` is high, and has no execute/memory match, selects 2'b01.
- R3: When both `mem_rd` and `wb_rd` match a source and both write enables are high, the select is 2'b10.
- R4: A stage whose write enable is low never causes forwarding or a stall, even if its destination number matches.
- R5: A source register numbered 0 never forwards and never causes a stall.
- R6: When `ex_load` and `ex_wen` are high and `ex_rd` equals a nonzero decode source, `stall` is high in that same cycle.
- R7: A producer in execute that is not a load never causes `stall`.
- R8: `stall` is never high in two consecutive cycles. In the cycle after a stall it is low, even if the load-use condition is still present.
- R9: `bubble` equals `stall` in every cycle.
- R10: While `rst_n` is low, the one-cycle limit is cleared. A load-use condition then raises `stall` in every cycle.
- R11: Write-after-write and write-after-read cases raise nothing. If the destinations match each other but no source, both selects are 2'b00 and `stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs1 | input | AW | First source register of the decode instruction |
| id_rs2 | input | AW | Second source register of the decode instruction |
| ex_rs1 | input | AW | First source register of the execute instruction |
| ex_rs2 | input | AW | Second source register of the execute instruction |
| ex_rd | input | AW | Destination register held in decode/execute |
| ex_wen | input | 1 | Decode/execute instruction writes a register |
| ex_load | input | 1 | Decode/execute instruction is a load |
| mem_rd | input | AW | Destination register held in execute/memory |
| mem_wen | input | 1 | Execute/memory instruction writes a register |
| wb_rd | input | AW | Destination register held in memory/writeback |
| wb_wen | input | 1 | Memory/writeback instruction writes a register |
| fwd_a | output | 2 | Select for the first ALU operand |
| fwd_b | output | 2 | Select for the second ALU operand |
| stall | output | 1 | Hold the PC and the fetch/decode register |
| bubble | output | 1 | Load a no-op into the decode/execute register |

## Verification
The assertions check on every cycle that `stall` and `bubble` agree, that no stall follows a stall, and that a non-load never stalls. They also check the bypass priority and the register-0 exclusion for operand A. The bench's scenarios are needed for the rest. They show that an interlock held through reset repeats every cycle and that a condition still present after a stall is dropped. They also show that mixed destination collisions leave both selects at the register file, with expected values compared cycle by cycle under random register numbers drawn from a small range so that matches happen often.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] rd,
  input  logic          wen,
  output logic          hit
);
  localparam logic [AW-1:0] ZERO_REG = '0;
  assign hit = wen && (src != ZERO_REG) && (src == rd);
endmodule

// File: rtl/hz_fwd_select.sv
module hz_fwd_select
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic [1:0]    sel
);
  logic mem_hit, wb_hit;
  fwd_sel_e choice;

  hz_src_match #(.AW(AW)) u_mem (.src(src), .rd(mem_rd), .wen(mem_wen), .hit(mem_hit));
  hz_src_match #(.AW(AW)) u_wb  (.src(src), .rd(wb_rd),  .wen(wb_wen),  .hit(wb_hit));

  // newest producer first
  always_comb begin
    if (mem_hit)     choice = FWD_MEM;
    else if (wb_hit) choice = FWD_WB;
    else             choice = FWD_RF;
  end

  assign sel = choice;
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC*AW-1:0] id_src,
  input  logic [AW-1:0]    ex_rd,
  input  logic             ex_wen,
  input  logic             ex_load,
  output logic             stall
);
  logic [NSRC-1:0] hit;
  logic            stall_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    hz_src_match #(.AW(AW)) u_m (
      .src(id_src[i*AW +: AW]),
      .rd (ex_rd),
      .wen(ex_wen && ex_load),
      .hit(hit[i])
    );
  end

  // the stalled cycle always puts a bubble into execute, so one cycle suffices
  assign stall = (|hit) && !stall_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= stall;
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          stall,
  output logic          bubble
);
  localparam int NOPS = 2;

  logic [NOPS*AW-1:0] ex_src;
  logic [NOPS*AW-1:0] id_src;
  logic [NOPS*2-1:0]  sel_all;

  assign ex_src = {ex_rs2, ex_rs1};
  assign id_src = {id_rs2, id_rs1};

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    hz_fwd_select #(.AW(AW)) u_sel (
      .src    (ex_src[k*AW +: AW]),
      .mem_rd (mem_rd),
      .mem_wen(mem_wen),
      .wb_rd  (wb_rd),
      .wb_wen (wb_wen),
      .sel    (sel_all[k*2 +: 2])
    );
  end

  assign fwd_a = sel_all[1:0];
  assign fwd_b = sel_all[3:2];

  hz_load_use #(.AW(AW), .NSRC(NOPS)) u_lu (
    .clk    (clk),
    .rst_n  (rst_n),
    .id_src (id_src),
    .ex_rd  (ex_rd),
    .ex_wen (ex_wen),
    .ex_load(ex_load),
    .stall  (stall)
  );

  assign bubble = stall;
endmodule

// File: rtl/hazard_unit_checker.sv
module hazard_unit_checker #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] ex_rs1,
  input logic          ex_load,
  input logic [AW-1:0] mem_rd,
  input logic          mem_wen,
  input logic [AW-1:0] wb_rd,
  input logic          wb_wen,
  input logic [1:0]    fwd_a,
  input logic          stall,
  input logic          bubble
);
  a_r3_mem_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen && ex_rs1 != '0 && ex_rs1 == mem_rd) |-> fwd_a == 2'b10);

  a_r2_wb_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_wen && ex_rs1 != '0 && ex_rs1 == wb_rd && !(mem_wen && ex_rs1 == mem_rd)) |-> fwd_a == 2'b01);

  a_r5_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1 == '0) |-> fwd_a == 2'b00);

  a_r7_no_load_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_load |-> !stall);

  a_r8_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  a_r9_bubble_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    bubble == stall);
endmodule

bind hazard_unit hazard_unit_checker #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .ex_rs1(ex_rs1), .ex_load(ex_load),
  .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
  .fwd_a(fwd_a), .stall(stall), .bubble(bubble)
);

// File: tb/test_hazard_unit.sv
`timescale 1ns/1ps
module test_hazard_unit;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic ex_wen, ex_load, mem_wen, wb_wen;
  logic [1:0] fwd_a, fwd_b;
  logic stall, bubble;

  int checks = 0;
  int errors = 0;
  bit prev_stall = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hazard_unit #(.AW(AW)) i_hazard_unit (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_wen(ex_wen),
    .ex_load(ex_load), .mem_rd(mem_rd), .mem_wen(mem_wen),
    .wb_rd(wb_rd), .wb_wen(wb_wen), .fwd_a(fwd_a), .fwd_b(fwd_b),
    .stall(stall), .bubble(bubble)
  );

  function automatic logic [1:0] exp_fwd(logic [AW-1:0] s);
    if (s != 0 && mem_wen && mem_rd == s) return 2'b10;
    if (s != 0 && wb_wen && wb_rd == s)   return 2'b01;
    return 2'b00;
  endfunction

  function automatic bit exp_stall();
    bit hit;
    hit = ex_load && ex_wen && ex_rd != 0 && (id_rs1 == ex_rd || id_rs2 == ex_rd);
    return hit && !prev_stall;
  endfunction

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; mem_rd = 0; wb_rd = 0;
    ex_wen = 0; ex_load = 0; mem_wen = 0; wb_wen = 0;
  endtask

  // inputs already set after the falling edge; sample 1 ns later
  task automatic settle_and_check(string tag);
    bit es;
    #1;
    es = exp_stall();
    chk({tag, " fwd_a"}, fwd_a, exp_fwd(ex_rs1));
    chk({tag, " fwd_b"}, fwd_b, exp_fwd(ex_rs2));
    chk({tag, " stall"}, {1'b0, stall}, {1'b0, es});
    chk({"R9 ", tag, " bubble"}, {1'b0, bubble}, {1'b0, stall});
    prev_stall = rst_n ? es : 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    clear_in();
    @(negedge clk);
    #1;
    chk("R10 reset fwd_a", fwd_a, 2'b00);
    chk("R10 reset stall", {1'b0, stall}, 2'b00);
    // hazard held through reset: stalls each cycle
    @(negedge clk); ex_load = 1; ex_wen = 1; ex_rd = 9; id_rs1 = 9;
    #1; chk("R10 reset cycle1 stall", {1'b0, stall}, 2'b01);
    @(negedge clk);
    #1; chk("R10 reset cycle2 stall", {1'b0, stall}, 2'b01);
    @(negedge clk); clear_in(); rst_n = 1'b1; prev_stall = 1'b0;
    settle_and_check("R10 after reset");

    @(negedge clk); clear_in(); ex_rs1 = 3; mem_rd = 3; mem_wen = 1;
    settle_and_check("R1 mem match");
    @(negedge clk); clear_in(); ex_rs2 = 4; wb_rd = 4; wb_wen = 1;
    settle_and_check("R2 wb match");
    @(negedge clk); clear_in(); ex_rs1 = 5; ex_rs2 = 5; mem_rd = 5; wb_rd = 5; mem_wen = 1; wb_wen = 1;
    settle_and_check("R3 both match");
    @(negedge clk); clear_in(); ex_rs1 = 5; mem_rd = 5; wb_rd = 5;
    ex_load = 1; ex_rd = 2; id_rs1 = 2;
    settle_and_check("R4 wen low");
    @(negedge clk); clear_in(); mem_wen = 1; wb_wen = 1;
    ex_load = 1; ex_wen = 1;
    settle_and_check("R5 zero reg");
    @(negedge clk); clear_in(); ex_load = 1; ex_wen = 1; ex_rd = 6; id_rs2 = 6;
    settle_and_check("R6 load use");
    // same condition held: must not repeat
    @(negedge clk);
    settle_and_check("R8 held after stall");
    @(negedge clk);
    settle_and_check("R6 again after gap");
    @(negedge clk); clear_in(); ex_wen = 1; ex_rd = 6; id_rs1 = 6; id_rs2 = 6;
    settle_and_check("R7 alu producer");
    @(negedge clk); clear_in(); ex_rd = 7; mem_rd = 7; wb_rd = 7;
    ex_wen = 1; mem_wen = 1; wb_wen = 1; ex_rs1 = 1; ex_rs2 = 2; id_rs1 = 1; id_rs2 = 2;
    settle_and_check("R11 waw war");
    #1;
    chk("R11 fwd_a rf", fwd_a, 2'b00);
    chk("R11 stall low", {1'b0, stall}, 2'b00);

    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      id_rs1 = AW'($urandom_range(0, 3)); id_rs2 = AW'($urandom_range(0, 3));
      ex_rs1 = AW'($urandom_range(0, 3)); ex_rs2 = AW'($urandom_range(0, 3));
      ex_rd  = AW'($urandom_range(0, 3)); mem_rd = AW'($urandom_range(0, 3));
      wb_rd  = AW'($urandom_range(0, 3));
      ex_wen = 1'($urandom); ex_load = 1'($urandom);
      mem_wen = 1'($urandom); wb_wen = 1'($urandom);
      settle_and_check("R1/R2/R3/R4/R5/R6/R7/R8 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule